// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream in two stages. A storage register takes a snapshot of the parallel inputs whenever the storage strobe rises. A separate shift register either follows that snapshot, when the mode select is low, or shifts one bit per rising edge of the shift strobe, when the mode select is high. In shift mode each step pushes the serial input into the first stage, and the last stage is always visible on the serial output.

Both strobes are ordinary signals in the system clock domain. The block registers each strobe and detects a 0-to-1 change, so every rising strobe edge produces exactly one clock of action. A strobe held high does not repeat its action. The serial output is paired with a drive-enable flag, which takes the place of a three-state pin. The active-low output enable affects only that flag and never touches either register.

Top module: `latched_piso`

## Requirements
- R1: A rising edge of `cap_stb` copies `par_in` into the storage register. Bit 0 of `par_in` maps to the first shift stage and bit WIDTH-1 maps to the last stage, the one seen on `ser_out`.
- R2: The storage register keeps its value whenever there is no rising edge of `cap_stb`, including while `cap_stb` is held high and `par_in` changes.
- R3: With `shift_mode` = 1, a rising edge of `sh_stb` moves every stage up by one and places `ser_in` in stage 0. `ser_out` then shows the bit that stage WIDTH-2 held before the edge.
- R4: With `shift_mode` = 1 and no rising edge of `sh_stb`, the shift register holds its value, whatever `ser_in` does.
- R5: With `shift_mode` = 0, the shift register copies the storage register on every clock. `ser_in` and `sh_stb` edges then have no effect.
- R6: If a storage capture happens in a clock where `shift_mode` = 0, the shift register takes the value the storage register held before that capture.
- R7: `ser_drive` equals the inverse of `oe_n` with no clock delay. `ser_out` always shows the last shift stage.
- R8: `oe_n` has no effect on the contents of the storage register or the shift register.
- R9: A synchronous active-high `rst` clears both registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel word; bit 0 goes to the first stage |
| ser_in | input | 1 | Serial data into stage 0 |
| cap_stb | input | 1 | Storage strobe; acts on its rising edge |
| sh_stb | input | 1 | Shift strobe; acts on its rising edge |
| shift_mode | input | 1 | 1 = shift, 0 = follow the storage register |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last shift stage |
| ser_drive | output | 1 | 1 when `ser_out` is driven, 0 for high impedance |

## Verification
Two functions can fall in the same clock: a storage capture and the level-driven transfer into the shifter. The bench provokes this by raising `cap_stb` with a new word while `shift_mode` is low, then raising `shift_mode` at the following falling clock edge, which freezes the shifter before the next transfer. It judges the result by shifting the shifter out, which must give the old stored word. A second transfer must then give the new word.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic {
    SR_FOLLOW = 1'b0,
    SR_SHIFT  = 1'b1
  } sr_mode_e;

  // a 0-to-1 change between the previous and the current sample
  function automatic logic rise(input logic now_v, input logic before_v);
    return now_v & ~before_v;
  endfunction

endpackage

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic fire
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= stb;
  end

  assign fire = piso_pkg::rise(stb, prev_q);

  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R2
endmodule

// File: rtl/piso_store.sv
module piso_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap |=> q == $past(d)); // R1
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q)); // R2
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sr_mode_e         mode,
  input  logic             step,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cur,
                                               input logic b);
    return {cur[TOP-1:0], b};
  endfunction

  logic do_load, do_step;
  assign do_load = (mode == SR_FOLLOW);
  assign do_step = (mode == SR_SHIFT) && step;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (do_load) q <= load_val;
    else if (do_step) q <= advance(q, ser_in);
  end

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == SR_SHIFT && step) |=> (q[TOP:1] == $past(q[TOP-1:0]) && q[0] == $past(ser_in))); // R3
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == SR_SHIFT && !step) |=> $stable(q)); // R4
  AST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (mode == SR_FOLLOW) |=> q == $past(load_val)); // R5
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             cap_stb,
  input  logic             sh_stb,
  input  logic             shift_mode,
  input  logic             oe_n,
  output logic             ser_out,
  output logic             ser_drive
);
  localparam int TOP = WIDTH - 1;

  logic             cap_fire, sh_fire;
  logic [WIDTH-1:0] store_q, sr_q;
  sr_mode_e         mode;

  assign mode = sr_mode_e'(shift_mode);

  piso_edge u_cap_edge (.clk(clk), .rst(rst), .stb(cap_stb), .fire(cap_fire));
  piso_edge u_sh_edge  (.clk(clk), .rst(rst), .stb(sh_stb),  .fire(sh_fire));

  piso_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .cap(cap_fire), .d(par_in), .q(store_q)
  );

  piso_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .mode(mode), .step(sh_fire), .ser_in(ser_in),
    .load_val(store_q), .q(sr_q)
  );

  assign ser_out   = sr_q[TOP];
  assign ser_drive = ~oe_n;

  AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (rst)
    (cap_fire && mode == SR_FOLLOW) |=> sr_q == $past(store_q)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (store_q == '0 && sr_q == '0)); // R9
endmodule

// File: tb/sim_latched_piso.sv
module sim_latched_piso;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0, cap_stb = 1'b0, sh_stb = 1'b0;
  logic         shift_mode = 1'b1, oe_n = 1'b0;
  logic         ser_out, ser_drive;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_piso #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in), .cap_stb(cap_stb),
    .sh_stb(sh_stb), .shift_mode(shift_mode), .oe_n(oe_n),
    .ser_out(ser_out), .ser_drive(ser_drive)
  );

  function automatic logic [W-1:0] push(input logic [W-1:0] v, input logic b);
    logic [W-1:0] r;
    for (int i = W-1; i > 0; i--) r[i] = v[i-1];
    r[0] = b;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cap_pulse(input logic [W-1:0] w);
    @(negedge clk); par_in = w; cap_stb = 1'b1;
    @(negedge clk); cap_stb = 1'b0;
  endtask

  task automatic step_pulse(input logic b);
    @(negedge clk); ser_in = b; sh_stb = 1'b1;
    @(negedge clk); sh_stb = 1'b0;
  endtask

  // shifts the register out (mode high), zeros fill behind
  task automatic read_shift(output logic [W-1:0] w);
    w[W-1] = ser_out;
    for (int i = W-2; i >= 0; i--) begin
      step_pulse(1'b0);
      w[i] = ser_out;
    end
    @(negedge clk);
  endtask

  task automatic read_store(output logic [W-1:0] w);
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); shift_mode = 1'b1;
    read_shift(w);
  endtask

  task automatic t_reset();
    logic [W-1:0] w;
    chk("R9 ser_out after reset", ser_out, 0);
    read_store(w);
    chk("R9 storage after reset", w, 0);
  endtask

  task automatic t_capture();
    logic [W-1:0] w;
    cap_pulse(8'h80);
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); shift_mode = 1'b1;
    chk("R1 bit W-1 lands on last stage", ser_out, 1);
    cap_pulse(8'hA5);
    read_store(w);
    chk("R1 captured word", w, 8'hA5);
  endtask

  task automatic t_level_hold();
    logic [W-1:0] w;
    @(negedge clk); par_in = 8'h3C; cap_stb = 1'b1;
    @(negedge clk); par_in = 8'hFF;
    @(negedge clk); par_in = 8'h00;
    @(negedge clk); cap_stb = 1'b0; par_in = 8'h99;
    read_store(w);
    chk("R2 held strobe captures once", w, 8'h3C);
  endtask

  task automatic t_shift();
    logic [W-1:0] m, w;
    logic [3:0] pat = 4'b1101;
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); shift_mode = 1'b1;
    m = 8'h3C;
    for (int i = 0; i < 4; i++) begin
      step_pulse(pat[i]);
      m = push(m, pat[i]);
      chk("R3 ser_out after step", ser_out, m[W-1]);
      @(negedge clk);
    end
    read_shift(w);
    chk("R3 shifter after steps", w, m);
  endtask

  task automatic t_hold_mode_high();
    logic [W-1:0] w;
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); shift_mode = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ser_in = i[0];
    end
    ser_in = 1'b0;
    read_shift(w);
    chk("R4 no strobe holds shifter", w, 8'h3C);
  endtask

  task automatic t_follow_ignores();
    logic [W-1:0] w;
    @(negedge clk); shift_mode = 1'b0;
    for (int i = 0; i < 3; i++) step_pulse(1'b1);
    @(negedge clk); ser_in = 1'b0; shift_mode = 1'b1;
    read_shift(w);
    chk("R5 follow mode ignores serial/strobe", w, 8'h3C);
  endtask

  task automatic t_same_cycle();
    logic [W-1:0] w;
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); par_in = 8'hC3; cap_stb = 1'b1;
    @(negedge clk); cap_stb = 1'b0; shift_mode = 1'b1;
    read_shift(w);
    chk("R6 shifter got old storage", w, 8'h3C);
    read_store(w);
    chk("R6 storage has new word", w, 8'hC3);
  endtask

  task automatic t_oe();
    logic [W-1:0] w;
    @(negedge clk); oe_n = 1'b1; #1;
    chk("R7 drive off", ser_drive, 0);
    oe_n = 1'b0; #1;
    chk("R7 drive on", ser_drive, 1);
    oe_n = 1'b1;
    cap_pulse(8'h5A);
    @(negedge clk); shift_mode = 1'b0;
    @(negedge clk); shift_mode = 1'b1;
    chk("R7 ser_out shows last stage while undriven", ser_out, 0);
    step_pulse(1'b1);
    @(negedge clk); oe_n = 1'b0;
    read_shift(w);
    chk("R8 shifter unaffected by oe_n", w, push(8'h5A, 1'b1));
    oe_n = 1'b1;
    read_store(w);
    oe_n = 1'b0;
    chk("R8 storage unaffected by oe_n", w, 8'h5A);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_capture();
    t_level_hold();
    t_shift();
    t_hold_mode_high();
    t_follow_ignores();
    t_same_cycle();
    t_oe();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule